// File: doc/BRIEF.md
# Preamble Edge-Window Checker

This block decides whether a demodulated data stream looks like a real preamble before a receiver moves into full receive mode. It runs a counter that advances on a base timing tick and measures the time between signal edges of either polarity. Each of these edge-to-edge intervals must land inside a window set by two programmable limits. Once a selectable number of intervals in a row have been accepted, the block raises a one-cycle pass strobe. If the checker instead finds an interval that is too short, or if its counter runs up to the upper limit, it raises a one-cycle fail strobe and goes back to waiting for a fresh first edge.

The block is armed by holding `enable` high. It ignores the data line until `startup_done` shows that the demodulator output has settled. The first edge after arming only starts the timing and is never judged itself. After a pass the block stays quiet until `enable` is dropped and raised again. The data input is asynchronous to the clock and is passed through a two-flop synchroniser.

Top module: `preamble_window_chk`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `pass_o` and `fail_o` are low.
- R2: While `enable` or `startup_done` is low, edges on `data_in` are ignored and neither strobe is raised.
- R3: After arming, the first edge only starts the interval counter. The time between arming and that first edge is not checked, however long it is.
- R4: The interval counter advances by one only in cycles where `tick` is high. The value judged at an edge counts the tick-high cycles from the cycle of the previous edge up to, but not including, the cycle of this edge. While `tick` is low the counter holds.
- R5: An edge that arrives while the count is below `lim_lo` causes a fail.
- R6: When the count reaches `lim_hi`, a fail occurs without any edge. This check takes priority over an edge in the same cycle, so the accepted window is `lim_lo` to `lim_hi`−1 ticks.
- R7: An edge of either polarity that arrives inside the window is accepted and restarts the interval.
- R8: `bits_sel` selects the number of accepted intervals required for a pass: 0 selects 3, 1 selects 6, 2 or 3 selects 9.
- R9: `pass_o` is high for exactly one cycle. No further strobe appears until `enable` has been low.
- R10: `fail_o` is high for exactly one cycle. The edge that caused the fail is consumed. The next edge starts a new sequence with the accepted count cleared, so a later pass is possible without re-arming.
- R11: With `tick` held high, a strobe caused by an edge appears 3 clocks after the `data_in` change. An overflow fail appears `lim_hi`+3 clocks after the change that started the interval.
- R12: `pass_o` and `fail_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Arms the checker; dropping it re-arms after a pass |
| startup_done | input | 1 | High once the demodulator output is valid |
| tick | input | 1 | Base timing tick, one-cycle enable for the interval counter |
| data_in | input | 1 | Demodulated data, asynchronous |
| lim_lo | input | 6 | Lower window limit in ticks (legal minimum 10) |
| lim_hi | input | 6 | Upper limit in ticks; reaching it fails (legal maximum 63) |
| bits_sel | input | 2 | Required interval count: 0→3, 1→6, 2/3→9 |
| pass_o | output | 1 | One-cycle strobe: preamble accepted |
| fail_o | output | 1 | One-cycle strobe: interval out of window |

## Verification
The in-module assertions check on every cycle that the two strobes exclude each other and last one cycle each. They also check that no strobe appears while the checker is not armed, that an overflowing count always produces a fail, and that the counter holds when the tick is low. Which strobe appears, and in which exact cycle, depends on whole edge sequences. The bench therefore sweeps constant intervals across each window and beyond both limits for several limit and count settings. It places a single bad interval at every position of a sequence, and holds the tick low over a long gap. For each run it predicts the complete chain of strobes arithmetically.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    localparam int NB_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_MEAS  = 2'd2,
        ST_DONE  = 2'd3
    } pwc_state_e;

    typedef struct packed {
        pwc_state_e      state;
        logic [NB_W-1:0] nbits;
        logic            pass;
        logic            fail;
    } pwc_ctl_t;

    function automatic logic [NB_W-1:0] bits_target(input logic [1:0] sel);
        case (sel)
            2'd0:    return NB_W'(3);
            2'd1:    return NB_W'(6);
            default: return NB_W'(9);
        endcase
    endfunction
endpackage

// File: rtl/pwc_edge_sync.sv
module pwc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o
);
    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sync_d = din;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], din};
        end
    endgenerate

    always_comb begin
        prev_d = sync_q[STAGES-1];
        edge_o = sync_q[STAGES-1] ^ prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/pwc_interval_cnt.sv
module pwc_interval_cnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         restart,
    input  logic         tick,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)                         cnt_d = '0;
        else if (restart)                  cnt_d = W'(tick);
        else if (tick && cnt_q != CNT_MAX) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R4
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear && !restart) |=> $stable(cnt_q));
endmodule

// File: rtl/preamble_window_chk.sv
module preamble_window_chk
    import pwc_pkg::*;
#(
    parameter int LIM_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             startup_done,
    input  logic             tick,
    input  logic             data_in,
    input  logic [LIM_W-1:0] lim_lo,
    input  logic [LIM_W-1:0] lim_hi,
    input  logic [1:0]       bits_sel,
    output logic             pass_o,
    output logic             fail_o
);
    logic             edge_w;
    logic [LIM_W-1:0] cnt_w;
    logic             cnt_clear, cnt_restart;
    logic [NB_W-1:0]  nb_inc;
    logic             armed;
    pwc_ctl_t         ctl_d, ctl_q;

    pwc_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (data_in),
        .edge_o (edge_w)
    );

    pwc_interval_cnt #(.W(LIM_W)) cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .restart (cnt_restart),
        .tick    (tick),
        .cnt_o   (cnt_w)
    );

    always_comb begin
        armed       = enable && startup_done;
        nb_inc      = ctl_q.nbits + NB_W'(1);
        ctl_d       = ctl_q;
        ctl_d.pass  = 1'b0;
        ctl_d.fail  = 1'b0;
        cnt_clear   = 1'b0;
        cnt_restart = 1'b0;
        if (!armed) begin
            ctl_d.state = ST_IDLE;
            ctl_d.nbits = '0;
            cnt_clear   = 1'b1;
        end else begin
            case (ctl_q.state)
                ST_IDLE: begin
                    ctl_d.state = ST_FIRST;
                    cnt_clear   = 1'b1;
                end
                ST_FIRST: begin
                    ctl_d.nbits = '0;
                    if (edge_w) begin
                        ctl_d.state = ST_MEAS;
                        cnt_restart = 1'b1;
                    end else begin
                        cnt_clear = 1'b1;
                    end
                end
                ST_MEAS: begin
                    if (cnt_w >= lim_hi) begin
                        ctl_d.fail  = 1'b1;
                        ctl_d.state = ST_FIRST;
                        ctl_d.nbits = '0;
                        cnt_clear   = 1'b1;
                    end else if (edge_w) begin
                        if (cnt_w < lim_lo) begin
                            ctl_d.fail  = 1'b1;
                            ctl_d.state = ST_FIRST;
                            ctl_d.nbits = '0;
                            cnt_clear   = 1'b1;
                        end else if (nb_inc == bits_target(bits_sel)) begin
                            ctl_d.pass  = 1'b1;
                            ctl_d.state = ST_DONE;
                            ctl_d.nbits = '0;
                            cnt_clear   = 1'b1;
                        end else begin
                            ctl_d.nbits = nb_inc;
                            cnt_restart = 1'b1;
                        end
                    end
                end
                default: begin
                    cnt_clear = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.nbits <= '0;
            ctl_q.pass  <= 1'b0;
            ctl_q.fail  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pass_o = ctl_q.pass;
    assign fail_o = ctl_q.fail;

    // R12
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));

    // R9
    pass_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |=> !pass_o);

    // R10
    fail_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> !fail_o);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable && startup_done) |=> (!pass_o && !fail_o));

    // R6
    overflow_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && startup_done && ctl_q.state == ST_MEAS && cnt_w >= lim_hi) |=> fail_o);
endmodule

// File: tb/preamble_window_chk_tb_top.sv
module preamble_window_chk_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       startup_done = 1'b0;
    logic       tick = 1'b1;
    logic       data_in = 1'b0;
    logic [5:0] lim_lo = 6'd10;
    logic [5:0] lim_hi = 6'd16;
    logic [1:0] bits_sel = 2'd0;
    logic       pass_o, fail_o;

    always #4 clk = ~clk;

    preamble_window_chk dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .startup_done(startup_done),
        .tick(tick), .data_in(data_in), .lim_lo(lim_lo), .lim_hi(lim_hi),
        .bits_sel(bits_sel), .pass_o(pass_o), .fail_o(fail_o)
    );

    int n_chk = 0, n_bad = 0, cyc = 0, ns = 0, both_cnt = 0;
    int sk[16], stm[16];
    int dd[32], tt[33];
    int n_iv, lo, hi, tgt;
    bit finished = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        if (pass_o && fail_o) both_cnt++;
        if (pass_o || fail_o) begin
            if (ns < 16) begin
                sk[ns]  = pass_o ? 1 : 2;
                stm[ns] = cyc;
            end
            ns++;
        end
    endtask

    // kind: 0 none, 1 pass, 2 fail
    task automatic model(input int s, output int kind, output int tm, output int nxt);
        int c = 0;
        kind = 0; tm = 0; nxt = -1;
        for (int i = s; i <= n_iv; i++) begin
            if (i == n_iv) begin kind = 2; tm = tt[i] + hi + 3; return; end
            if (dd[i] >= hi) begin
                kind = 2; tm = tt[i] + hi + 3; nxt = (dd[i] == hi) ? i + 2 : i + 1; return;
            end
            if (dd[i] < lo) begin kind = 2; tm = tt[i + 1] + 3; nxt = i + 2; return; end
            c++;
            if (c == tgt) begin kind = 1; tm = tt[i + 1] + 3; return; end
        end
    endtask

    task automatic run_case(input int sel, input string tag);
        int ek[16], et[16];
        int ne = 0, s = 0, k, t, nx;
        enable = 1'b0;
        repeat (3) step();
        lim_lo = 6'(lo); lim_hi = 6'(hi); bits_sel = 2'(sel);
        tgt = (sel == 0) ? 3 : (sel == 1) ? 6 : 9;
        ns = 0;
        enable = 1'b1; startup_done = 1'b1;
        repeat (70) step();        // R3: gap longer than any upper limit
        data_in = ~data_in; tt[0] = cyc;
        for (int i = 0; i < n_iv; i++) begin
            repeat (dd[i]) step();
            data_in = ~data_in; tt[i + 1] = cyc;
        end
        repeat (hi + 10) step();
        while (ne < 16) begin
            model(s, k, t, nx);
            if (k == 0) break;
            ek[ne] = k; et[ne] = t; ne++;
            if (k == 1 || nx < 0) break;
            s = nx;
        end
        check(ns == ne, {tag, "/R9"}, "strobe count", ns, ne);
        for (int j = 0; j < ne && j < ns && j < 2; j++) begin
            check(sk[j] == ek[j], tag, "strobe kind", sk[j], ek[j]);
            check(stm[j] == et[j], "R3/R11", "strobe cycle", stm[j], et[j]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int cfg_lo[5] = '{10, 14, 19, 12, 40};
        int cfg_hi[5] = '{16, 24, 26, 20, 63};
        int cfg_sel[5] = '{0, 1, 2, 3, 1};
        int t0;
        // R1
        repeat (3) begin
            step();
            check(!pass_o && !fail_o, "R1", "outputs in reset", {pass_o, fail_o}, 0);
        end
        rst_n = 1'b1;
        step();
        check(!pass_o && !fail_o, "R1", "outputs after reset", {pass_o, fail_o}, 0);

        // R2: data ignored before startup completes, and while disabled
        lim_lo = 6'd10; lim_hi = 6'd16; bits_sel = 2'd0;
        ns = 0; enable = 1'b1; startup_done = 1'b0;
        repeat (12) begin repeat (13) step(); data_in = ~data_in; end
        repeat (40) step();
        check(ns == 0, "R2", "strobes before startup", ns, 0);
        enable = 1'b0; startup_done = 1'b1;
        repeat (12) begin repeat (13) step(); data_in = ~data_in; end
        repeat (40) step();
        check(ns == 0, "R2", "strobes while disabled", ns, 0);

        // R5 R6 R7 R8: constant-interval sweep across and beyond each window
        for (int c = 0; c < 5; c++) begin
            lo = cfg_lo[c]; hi = cfg_hi[c];
            for (int d = lo - 1; d <= hi + 1; d++) begin
                int tg = (cfg_sel[c] == 0) ? 3 : (cfg_sel[c] == 1) ? 6 : 9;
                n_iv = tg + 2;
                for (int i = 0; i < n_iv; i++) dd[i] = d;
                run_case(cfg_sel[c], (d < lo) ? "R5" : (d >= hi) ? "R6" : "R7/R8");
            end
        end

        // R10: one bad interval at every position, good ones around it
        lo = 14; hi = 24;
        for (int j = 0; j < 6; j++) begin
            for (int b = 0; b < 3; b++) begin
                n_iv = j + 1 + 6 + 1;
                for (int i = 0; i < n_iv; i++) dd[i] = (i % 2 == 0) ? 14 : 23;
                dd[j] = (b == 0) ? 13 : (b == 1) ? 24 : 30;
                run_case(1, "R10");
            end
        end

        // R4: tick low freezes the counter
        enable = 1'b0;
        repeat (3) step();
        lim_lo = 6'd10; lim_hi = 6'd16; bits_sel = 2'd0;
        ns = 0; enable = 1'b1; startup_done = 1'b1; tick = 1'b1;
        repeat (20) step();
        tick = 1'b0;
        data_in = ~data_in;
        repeat (150) step();
        check(ns == 0, "R4", "strobes with tick low", ns, 0);
        tick = 1'b1; t0 = cyc;
        repeat (30) step();
        check(ns == 1, "R4", "strobe count after tick resumes", ns, 1);
        check(stm[0] == t0 + 17, "R4", "overflow cycle after tick resumes", stm[0], t0 + 17);
        check(sk[0] == 2, "R4", "overflow strobe kind", sk[0], 2);

        // R12
        check(both_cnt == 0, "R12", "cycles with both strobes", both_cnt, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule